// File: doc/BRIEF.md
# Frame Writeback Control Sequencer

This block runs the capture of one raster frame at a time from an upstream compositor into memory. Software sets up four values through a small register bus: a destination pointer, a line pitch in bytes, the frame dimensions and a control word. Software then sets the start bit in the control word. The sequencer asks the compositor for a frame and accepts the pixel lines one at a time. For each line it issues one memory-write request that carries the line base address. It counts the lines that memory acknowledges, and it returns to idle when the count reaches the programmed height. Pixel packing, tiled and rotated layouts and the real memory protocol belong to other blocks. The memory side is modelled as one request and acknowledge per line.

The control word combines a self-clearing start bit, a busy flag, an interrupt enable that raises the interrupt when the unit becomes idle, an immediate abort, a power-down bit that blocks new starts and a restart-request bit. It also carries fixed identification fields that read back the same value whatever is written. A separate progress register shows how many lines have been committed. The state machine has five named states:
- `ST_IDLE`: waiting for a start.
- `ST_FETCH`: a one-cycle request to the compositor for a frame.
- `ST_WAIT_LINE`: waiting for a line.
- `ST_WRITE`: the memory request is outstanding.
- `ST_DONE`: a one-cycle end-of-frame state.

The transitions are:
- **start**: `ST_IDLE`/`ST_DONE` to `ST_FETCH`, or to `ST_DONE` directly when the height is zero.
- **fetched**: `ST_FETCH` to `ST_WAIT_LINE`.
- **line arrives**: `ST_WAIT_LINE` to `ST_WRITE`.
- **line committed**: `ST_WRITE` to `ST_WAIT_LINE`, or to `ST_DONE` on the last line.
- **retire**: `ST_DONE` to `ST_IDLE`.
- **abort**: any busy state to `ST_IDLE`.

Top module: `fwb_ctrl_top`

## Requirements
- R1: The byte offsets are 0x00 pointer, 0x04 pitch, 0x08 dimensions (height in bits 31:16, of which the low LINE_W bits are used, width in bits 15:0), 0x0C control and 0x10 progress. Pointer, pitch and dimensions read back as written. Any other offset reads 0. Writes to the progress register are ignored.
- R2: Control reads bits 31:24 as 0x54 and bits 23:22 as 0x01 at all times. Bit 0 (start) and bit 14 (abort) read 0. Bit 1 reads the busy flag. Bits 21:15 and 13:2 read back as written.
- R3: A control write with bit 0 set, bit 14 clear and bit 21 clear, made while not busy and with a non-zero height, makes busy read 1 from the next cycle. `frame_req` pulses for exactly that one cycle.
- R4: While waiting, `line_ready` is high. A cycle with `line_valid` moves the unit to raise `mem_req` with `mem_addr` = pointer + k×pitch (modulo 2^ADDR_W) for line k. `mem_req` and `line_ready` are never high together, and `mem_req` holds until `mem_ack` or an abort.
- R5: Progress reads 0 after a start and rises by 1 on each `mem_ack`. When it equals the height, busy reads 0 in the following cycle and progress keeps its final value.
- R6: A start with height 0 produces no `line_ready` and no `mem_req`. Busy stays 0, and the frame ends in the cycle after the write.
- R7: The pointer, pitch and height are captured at start. Writes to them during a frame do not change the addresses or the line count of that frame.
- R8: A start write while busy is ignored. There is no new `frame_req`, and progress is not reset.
- R9: A start written together with bit 21 set is ignored: the unit stays idle. Bit 21 reads back 1.
- R10: A control write with bit 14 set while busy makes busy, `mem_req` and `line_ready` read 0 from the next cycle. No further memory request is issued, and progress keeps the count of committed lines. The same write made while idle has no effect on the state.
- R11: If control bit 2 is set when a frame ends (normal end or abort), `irq` rises in the cycle after the end. It stays high until a control write with bit 2 clear. If the bit is clear, `irq` stays low.
- R12: If control bit 15 is set, `frame_req` pulses for one cycle in the end-of-frame cycle, the cycle in which busy first reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset, for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| line_valid | input | 1 | Compositor presents a line |
| line_ready | output | 1 | Sequencer can accept a line |
| frame_req | output | 1 | Frame-start request pulse to the compositor |
| mem_req | output | 1 | Memory write request for the current line |
| mem_addr | output | ADDR_W | Base address of the current line |
| mem_ack | input | 1 | Memory has committed the line |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with LINE_W = 8 and ADDR_W = 32. With LINE_W = 8 the largest frame, 255 lines, fits into a short run, so the line counter is checked at its full range as well as over a sweep of heights 0 to 5. The sweep is crossed with three pitches, one of which places the lines across the top of the address space so that the address wrap is covered. It is also crossed with the settings of the interrupt enable and the restart request. Aborts are tested in both the waiting and the writing states. Rewrites of the registers during a frame and start attempts while busy are checked against line addresses that the bench computes independently.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    // register bus geometry
    localparam int unsigned FWB_AW = 5;
    localparam int unsigned FWB_DW = 32;

    localparam logic [FWB_AW-1:0] OFS_PTR   = 5'h00;
    localparam logic [FWB_AW-1:0] OFS_PITCH = 5'h04;
    localparam logic [FWB_AW-1:0] OFS_DIM   = 5'h08;
    localparam logic [FWB_AW-1:0] OFS_CTRL  = 5'h0C;
    localparam logic [FWB_AW-1:0] OFS_PROG  = 5'h10;

    // control word bit positions
    localparam int unsigned CB_GO    = 0;
    localparam int unsigned CB_BUSY  = 1;
    localparam int unsigned CB_IRQEN = 2;
    localparam int unsigned CB_ABORT = 14;
    localparam int unsigned CB_RSTRT = 15;
    localparam int unsigned CB_PDN   = 21;

    // fixed identification fields
    localparam logic [7:0] ID_MAGIC = 8'h54;
    localparam logic [1:0] ID_REV   = 2'b01;

    // height field position inside the dimensions word
    localparam int unsigned DIM_H_LSB = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_LINE,
        ST_WRITE,
        ST_DONE
    } fwb_state_e;

endpackage

// File: rtl/fwb_regfile.sv
module fwb_regfile
    import fwb_pkg::*;
#(
    parameter int unsigned LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [FWB_AW-1:0] addr,
    input  logic [FWB_DW-1:0] wdata,
    output logic [FWB_DW-1:0] rdata,
    input  logic              busy,
    input  logic [LINE_W-1:0] progress,
    input  logic              frame_end,
    output logic [FWB_DW-1:0] ptr,
    output logic [FWB_DW-1:0] pitch,
    output logic [LINE_W-1:0] height,
    output logic              start_cmd,
    output logic              abort_cmd,
    output logic              restart_en,
    output logic              irq
);

    localparam int unsigned PAD_W = FWB_DW - LINE_W;

    logic [FWB_DW-1:0]   ptr_q, pitch_q, dim_q;
    logic [CB_PDN:CB_IRQEN] ctrl_q;
    logic                irq_q;
    logic                ctrl_wr;
    logic                irqen_eff;

    assign ctrl_wr   = wr && (addr == OFS_CTRL);
    assign start_cmd = ctrl_wr && wdata[CB_GO] && !wdata[CB_ABORT] && !wdata[CB_PDN];
    assign abort_cmd = ctrl_wr && wdata[CB_ABORT];
    assign irqen_eff = ctrl_wr ? wdata[CB_IRQEN] : ctrl_q[CB_IRQEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            pitch_q <= '0;
            dim_q   <= '0;
            ctrl_q  <= '0;
        end else if (wr) begin
            case (addr)
                OFS_PTR:   ptr_q   <= wdata;
                OFS_PITCH: pitch_q <= wdata;
                OFS_DIM:   dim_q   <= wdata;
                OFS_CTRL: begin
                    ctrl_q           <= wdata[CB_PDN:CB_IRQEN];
                    ctrl_q[CB_ABORT] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // interrupt pending flag: set at a frame end when enabled, cleared by software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (frame_end && irqen_eff) begin
            irq_q <= 1'b1;
        end else if (ctrl_wr && !wdata[CB_IRQEN]) begin
            irq_q <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            OFS_PTR:   rdata = ptr_q;
            OFS_PITCH: rdata = pitch_q;
            OFS_DIM:   rdata = dim_q;
            OFS_CTRL:  rdata = {ID_MAGIC, ID_REV, ctrl_q, busy, 1'b0};
            OFS_PROG:  rdata = {{PAD_W{1'b0}}, progress};
            default:   rdata = '0;
        endcase
    end

    assign ptr        = ptr_q;
    assign pitch      = pitch_q;
    assign height     = dim_q[DIM_H_LSB +: LINE_W];
    assign restart_en = ctrl_q[CB_RSTRT];
    assign irq        = irq_q;

    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(frame_end))
        else $error("irq rose without a frame end");

endmodule

// File: rtl/fwb_line_addr.sv
module fwb_line_addr #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] line_addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;

    // base and stride are captured at start; later register writes do not reach here
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr_q   <= base;
            stride_q <= stride;
        end else if (advance) begin
            addr_q <= addr_q + stride_q;
        end
    end

    assign line_addr = addr_q;

endmodule

// File: rtl/fwb_frame_fsm.sv
module fwb_frame_fsm
    import fwb_pkg::*;
#(
    parameter int unsigned LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              abort_cmd,
    input  logic [LINE_W-1:0] height,
    input  logic              restart_en,
    input  logic              line_valid,
    input  logic              mem_ack,
    output logic              busy,
    output logic [LINE_W-1:0] progress,
    output logic              frame_end,
    output logic              frame_req,
    output logic              line_ready,
    output logic              mem_req,
    output logic              load,
    output logic              advance
);

    fwb_state_e        st_q, st_d;
    logic [LINE_W-1:0] prog_q, height_q;
    logic              last_line;
    logic              can_start;

    assign last_line = (LINE_W'(prog_q + 1'b1) == height_q);
    assign can_start = (st_q == ST_IDLE) || (st_q == ST_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start_cmd) st_d = (height == '0) ? ST_DONE : ST_FETCH;
                else           st_d = ST_IDLE;
            end
            ST_FETCH:     st_d = ST_WAIT_LINE;
            ST_WAIT_LINE: if (line_valid) st_d = ST_WRITE;
            ST_WRITE:     if (mem_ack) st_d = last_line ? ST_DONE : ST_WAIT_LINE;
            default:      st_d = ST_IDLE;
        endcase
        if (abort_cmd && busy) st_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        line_ready = 1'b0;
        mem_req    = 1'b0;
        frame_req  = 1'b0;
        unique case (st_q)
            ST_IDLE:      ;
            ST_FETCH:     begin busy = 1'b1; frame_req = 1'b1; end
            ST_WAIT_LINE: begin busy = 1'b1; line_ready = 1'b1; end
            ST_WRITE:     begin busy = 1'b1; mem_req = 1'b1; end
            ST_DONE:      frame_req = restart_en;
            default:      ;
        endcase
        frame_end = (st_q == ST_DONE) || (abort_cmd && busy);
        load      = start_cmd && can_start;
        advance   = mem_req && mem_ack && !abort_cmd;
    end

    // committed-line counter and captured height
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q   <= '0;
            height_q <= '0;
        end else if (load) begin
            prog_q   <= '0;
            height_q <= height;
        end else if (advance) begin
            prog_q <= prog_q + 1'b1;
        end
    end

    assign progress = prog_q;

    assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && line_ready))
        else $error("memory request and line ready together");

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort_cmd) |=> mem_req)
        else $error("memory request dropped without acknowledge");

    assert_prog_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (prog_q < height_q))
        else $error("progress reached height while busy");

    assert_abort_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_cmd && busy) |=> (!busy && !mem_req && !line_ready))
        else $error("abort did not stop the frame");

endmodule

// File: rtl/fwb_ctrl_top.sv
module fwb_ctrl_top
    import fwb_pkg::*;
#(
    parameter int unsigned LINE_W = 16,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              line_valid,
    output logic              line_ready,
    output logic              frame_req,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic              irq
);

    logic [FWB_DW-1:0] ptr, pitch;
    logic [LINE_W-1:0] height, progress;
    logic              start_cmd, abort_cmd, restart_en;
    logic              busy, frame_end, load, advance;

    fwb_regfile #(.LINE_W(LINE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .busy       (busy),
        .progress   (progress),
        .frame_end  (frame_end),
        .ptr        (ptr),
        .pitch      (pitch),
        .height     (height),
        .start_cmd  (start_cmd),
        .abort_cmd  (abort_cmd),
        .restart_en (restart_en),
        .irq        (irq)
    );

    fwb_frame_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cmd  (start_cmd),
        .abort_cmd  (abort_cmd),
        .height     (height),
        .restart_en (restart_en),
        .line_valid (line_valid),
        .mem_ack    (mem_ack),
        .busy       (busy),
        .progress   (progress),
        .frame_end  (frame_end),
        .frame_req  (frame_req),
        .line_ready (line_ready),
        .mem_req    (mem_req),
        .load       (load),
        .advance    (advance)
    );

    fwb_line_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .base      (ptr[ADDR_W-1:0]),
        .stride    (pitch[ADDR_W-1:0]),
        .line_addr (mem_addr)
    );

    assert_start_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == OFS_CTRL && reg_wdata[CB_GO]
                              && !reg_wdata[CB_PDN]))
        else $error("frame began without a permitted start write");

endmodule

// File: tb/fwb_ctrl_top_tb.sv
module fwb_ctrl_top_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned LW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        line_valid = 1'b0;
    logic        line_ready;
    logic        frame_req;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwb_ctrl_top #(.LINE_W(LW), .ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_valid(line_valid),
        .line_ready(line_ready), .frame_req(frame_req), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_ready(input string req);
        int t = 0;
        while (!line_ready && t < 20) begin
            @(negedge clk);
            t++;
        end
        chk(req, {31'd0, line_ready}, 32'd1);
    endtask

    function automatic logic [31:0] ctrl_word(input bit ie, input bit rs);
        return 32'h1 | (32'(ie) << 2) | (32'(rs) << 15) | 32'h000F_0000;
    endfunction

    task automatic run_frame(input logic [31:0] p, input logic [31:0] pt,
                             input int h, input bit ie, input bit rs);
        logic [31:0] d;
        logic [31:0] cw;
        cw = ctrl_word(ie, rs);
        reg_write(5'h00, p);
        reg_write(5'h04, pt);
        reg_write(5'h08, {8'h00, 8'(h), 16'd320});
        reg_write(5'h0C, cw);
        if (h == 0) begin
            reg_read(5'h0C, d);
            chk("R6 busy", {31'd0, d[1]}, 32'd0);
            chk("R6 line_ready", {31'd0, line_ready}, 32'd0);
            chk("R6 mem_req", {31'd0, mem_req}, 32'd0);
            chk("R12 restart pulse", {31'd0, frame_req}, {31'd0, rs});
        end else begin
            reg_read(5'h0C, d);
            chk("R3 busy", {31'd0, d[1]}, 32'd1);
            chk("R3 frame_req", {31'd0, frame_req}, 32'd1);
            reg_read(5'h10, d);
            chk("R5 progress cleared", d, 32'd0);
            @(negedge clk);
            chk("R3 frame_req single", {31'd0, frame_req}, 32'd0);
            for (int k = 0; k < h; k++) begin
                if (k == 1 && h >= 3) begin
                    reg_write(5'h0C, cw);
                    chk("R8 no new request", {31'd0, frame_req}, 32'd0);
                    reg_read(5'h10, d);
                    chk("R8 progress kept", d, 32'd1);
                end
                wait_ready("R4 line_ready");
                line_valid = 1'b1;
                @(negedge clk);
                line_valid = 1'b0;
                chk("R4 mem_req", {31'd0, mem_req}, 32'd1);
                chk("R4 ready low", {31'd0, line_ready}, 32'd0);
                chk("R4 R7 line address", mem_addr, p + 32'(k) * pt);
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                reg_read(5'h10, d);
                chk("R5 progress count", d, 32'(k + 1));
                if (k == 0 && h >= 2) begin
                    reg_write(5'h00, ~p);
                    reg_write(5'h04, pt + 32'h100);
                    reg_write(5'h08, {8'h00, 8'd1, 16'd320});
                end
            end
            reg_read(5'h0C, d);
            chk("R5 busy low at end", {31'd0, d[1]}, 32'd0);
            chk("R12 restart pulse", {31'd0, frame_req}, {31'd0, rs});
        end
        @(negedge clk);
        chk("R11 irq after end", {31'd0, irq}, {31'd0, ie});
        chk("R12 restart single", {31'd0, frame_req}, 32'd0);
        if (ie) begin
            reg_write(5'h0C, 32'h0);
            chk("R11 irq cleared", {31'd0, irq}, 32'd0);
        end
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        logic [31:0] pitches [3];
        logic [31:0] bases [3];
        pitches[0] = 32'h10; pitches[1] = 32'h40; pitches[2] = 32'h1000;
        bases[0] = 32'h0001_0000; bases[1] = 32'h2000_0004; bases[2] = 32'hFFFF_E000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        reg_read(5'h0C, d); chk("R2 reset ctrl", d, 32'h5440_0000);
        reg_read(5'h00, d); chk("R1 reset ptr", d, 32'h0);
        reg_read(5'h10, d); chk("R1 reset progress", d, 32'h0);
        chk("R11 reset irq", {31'd0, irq}, 32'd0);
        chk("R4 reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R3 reset frame_req", {31'd0, frame_req}, 32'd0);

        // register readback
        reg_write(5'h00, 32'hDEAD_BEE0); reg_read(5'h00, d); chk("R1 ptr", d, 32'hDEAD_BEE0);
        reg_write(5'h04, 32'h0000_1230); reg_read(5'h04, d); chk("R1 pitch", d, 32'h0000_1230);
        reg_write(5'h08, 32'h0004_0280); reg_read(5'h08, d); chk("R1 dim", d, 32'h0004_0280);
        reg_read(5'h14, d); chk("R1 unmapped", d, 32'h0);
        reg_write(5'h10, 32'h0000_ABCD); reg_read(5'h10, d); chk("R1 progress read-only", d, 32'h0);

        // control field behaviour while idle; abort while idle is harmless
        reg_write(5'h0C, 32'hFFFF_FFFE);
        reg_read(5'h0C, d); chk("R2 all ones", d, 32'h547F_BFFC);
        chk("R10 idle abort no irq", {31'd0, irq}, 32'd0);
        reg_write(5'h0C, 32'h0);
        reg_read(5'h0C, d); chk("R2 zeros", d, 32'h5440_0000);

        // power-down blocks start
        reg_write(5'h0C, 32'h0020_0005);
        reg_read(5'h0C, d);
        chk("R9 busy stays low", {31'd0, d[1]}, 32'd0);
        chk("R9 pdn readback", {31'd0, d[21]}, 32'd1);
        chk("R9 no frame_req", {31'd0, frame_req}, 32'd0);
        @(negedge clk);
        chk("R9 no line_ready", {31'd0, line_ready}, 32'd0);
        reg_write(5'h0C, 32'h0);

        // sweep heights, pitches, interrupt enable and restart request
        for (int h = 0; h <= 5; h++) begin
            for (int j = 0; j < 3; j++) begin
                run_frame(bases[j], pitches[j], h, bit'(h % 2), bit'(j == 1));
            end
        end

        // full counter range
        run_frame(32'h4000_0000, 32'h4, 255, 1'b1, 1'b0);

        // abort while waiting for a line
        reg_write(5'h00, 32'h100); reg_write(5'h04, 32'h20);
        reg_write(5'h08, {8'h0, 8'd4, 16'd8});
        reg_write(5'h0C, ctrl_word(1'b1, 1'b0));
        for (int k = 0; k < 2; k++) begin
            wait_ready("R4 ready");
            line_valid = 1'b1; @(negedge clk); line_valid = 1'b0;
            mem_ack = 1'b1; @(negedge clk); mem_ack = 1'b0;
        end
        reg_write(5'h0C, 32'h0000_4004);
        reg_read(5'h0C, d); chk("R10 busy cleared", {31'd0, d[1]}, 32'd0);
        chk("R10 ready low", {31'd0, line_ready}, 32'd0);
        reg_read(5'h10, d); chk("R10 progress kept", d, 32'd2);
        chk("R11 irq on abort", {31'd0, irq}, 32'd1);
        reg_write(5'h0C, 32'h0);
        chk("R11 irq cleared", {31'd0, irq}, 32'd0);

        // abort while the memory request is outstanding
        reg_write(5'h0C, ctrl_word(1'b0, 1'b0));
        wait_ready("R4 ready");
        line_valid = 1'b1; @(negedge clk); line_valid = 1'b0;
        chk("R4 req before abort", {31'd0, mem_req}, 32'd1);
        reg_write(5'h0C, 32'h0000_4000);
        for (int t = 0; t < 5; t++) begin
            chk("R10 no request after abort", {31'd0, mem_req | line_ready}, 32'd0);
            line_valid = 1'b1;
            @(negedge clk);
        end
        line_valid = 1'b0;
        chk("R11 no irq when disabled", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule